// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block accepts the per-cycle control inputs of a flow-through synchronous burst SRAM and serves them from an internal array. On each rising clock edge it samples the following inputs:

- three chip enables;
- two address strobes: a processor-side strobe that can only start reads, and a controller-side strobe that starts a read or a write burst;
- an advance input;
- a global write, a byte write and one byte enable per lane.

From these it picks one cycle type: deselect, begin burst, continue burst or suspend burst. Writes land in the array at the edge that samples the command. Read data for the registered address flows straight out of the array in the following cycle, with no extra pipeline stage.

Inside a burst, the two low address bits step through four positions. The order is linear or interleaved, selected by a static mode input, and the upper address bits stay fixed. The data output carries a drive-enable flag that stands for the tri-state buffer. An asynchronous active-low output enable gates that flag, and a sleep input freezes the block while keeping its contents.

Top module: `sburst_ctrl`

## Requirements
- R1: After synchronous reset, `dout_en` is low and no burst is active, so strobe-less cycles do not drive data.
- R2: A cycle is a deselect when `adsc_n`=0 with `ce1_n`=1, or when a strobe is honoured while the enable (`ce2`=1 and `ce3_n`=0) is false. A deselect writes nothing and leaves `dout_en` low. Later strobe-less cycles stay idle until a new burst starts.
- R3: `adsp_n`=0 with `ce1_n`=0 and the enable true begins a read burst at `addr`, whatever the write inputs are. `adsp_n`=0 with `ce1_n`=1 is ignored, and the cycle is decoded as if that strobe were high.
- R4: `adsc_n`=0 with `adsp_n`=1, `ce1_n`=0 and the enable true begins a burst at `addr`. The burst is a write or a read according to the write decode.
- R5: The write decode works as follows. `gw_n`=0 writes all four lanes. Otherwise `bw_n`=0 writes each lane i whose `be_n[i]`=0, where lane i is `din[9i+8:9i]`. With `gw_n`=`bw_n`=1, or with no byte enable low, the cycle is a read.
- R6: With both strobes high inside a burst, `adv_n`=0 moves to the next burst address and `adv_n`=1 stays on the current one. Either case reads or writes according to the decode.
- R7: The low two address bits equal base+k mod 4 when `interleave`=0, and base XOR k when `interleave`=1. Here k counts the advances since the start. Upper bits are held, and the fifth position wraps to the start address.
- R8: Read data for the address used at an edge appears on `dout` with `dout_en` high during the cycle after that edge.
- R9: In the cycle after any write command, `dout_en` is low regardless of the byte enables.
- R10: `oe_n`=1 forces `dout_en` low at once without waiting for a clock edge. `oe_n`=0 drives only after a read. A read with `oe_n`=1 still advances the burst address.
- R11: While `sleep`=1, the block does no writes, keeps its burst position and holds `dout_en` low. After sleep ends, a continue proceeds from the pre-sleep position.
- R12: `ce2` and `ce3_n` are ignored on cycles with no honoured strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Freeze: no access, no state change, outputs off |
| ce1_n | input | 1 | Active-low enable checked with the strobes |
| ce2 | input | 1 | Active-high enable, sampled only with a strobe |
| ce3_n | input | 1 | Active-low enable, sampled only with a strobe |
| adsp_n | input | 1 | Processor-side burst start (read only) |
| adsc_n | input | 1 | Controller-side burst start |
| adv_n | input | 1 | Advance burst address when low |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| gw_n | input | 1 | Global write, all lanes |
| bw_n | input | 1 | Byte write qualifier |
| be_n | input | NB | Per-lane byte enables, active low |
| addr | input | AW | External word address |
| din | input | NB*LW | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | NB*LW | Read data (zero when not driven) |
| dout_en | output | 1 | Output drive enable (low means high-Z) |

## Verification
A controller-strobe start and the asynchronous output enable meet in one cycle, because a read registered with `oe_n` high has to appear as soon as `oe_n` falls within that same cycle. The bench checks this by toggling `oe_n` between clock edges. Two further collisions are exercised:

- A continue write issued right after a dummy read tests that the write lands at the advanced address and that the write cycle keeps `dout_en` low.
- A processor strobe presented while `ce1_n` is high, in the same cycle as a pending advance, tests that the advance wins. The bench judges this by the data returned from the next sequential address.

// File: rtl/sburst_pkg.sv
package sburst_pkg;

  typedef enum logic [2:0] {
    CYC_NONE,
    CYC_DESEL,
    CYC_START,
    CYC_NEXT,
    CYC_SAME
  } cyc_e;

  // Low two burst address bits for step k from base.
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] k,
                                           input logic       il);
    return il ? (base ^ k) : 2'(base + k);
  endfunction

endpackage

// File: rtl/sburst_decode.sv
module sburst_decode
  import sburst_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          sleep,
  input  logic          active,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          adsp_n,
  input  logic          adsc_n,
  input  logic          adv_n,
  input  logic          gw_n,
  input  logic          bw_n,
  input  logic [NB-1:0] be_n,
  output cyc_e          cyc,
  output logic [NB-1:0] wmask
);

  logic          en;
  logic [NB-1:0] dec_mask;

  always_comb begin
    en = ce2 & ~ce3_n;
    if (!gw_n)      dec_mask = '1;
    else if (!bw_n) dec_mask = ~be_n;
    else            dec_mask = '0;

    cyc   = CYC_NONE;
    wmask = '0;
    if (sleep) begin
      cyc = CYC_NONE;
    end else if (!adsp_n && !ce1_n) begin
      // processor strobe: read only
      cyc = en ? CYC_START : CYC_DESEL;
    end else if (!adsc_n) begin
      if (ce1_n || !en) begin
        cyc = CYC_DESEL;
      end else begin
        cyc   = CYC_START;
        wmask = dec_mask;
      end
    end else if (active) begin
      cyc   = adv_n ? CYC_SAME : CYC_NEXT;
      wmask = dec_mask;
    end
  end

endmodule

// File: rtl/sburst_addr_seq.sv
module sburst_addr_seq
  import sburst_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  cyc_e          cyc,
  input  logic          interleave,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] cur_addr,
  output logic          active
);

  localparam int HW = AW - 2;

  logic [HW-1:0] hi_q;
  logic [1:0]    base_q;
  logic [1:0]    cnt_q;

  always_comb begin
    case (cyc)
      CYC_START: cur_addr = addr_in;
      CYC_NEXT:  cur_addr = {hi_q, burst_low(base_q, 2'(cnt_q + 2'd1), interleave)};
      default:   cur_addr = {hi_q, burst_low(base_q, cnt_q, interleave)};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      active <= 1'b0;
    end else begin
      case (cyc)
        CYC_START: begin
          hi_q   <= addr_in[AW-1:2];
          base_q <= addr_in[1:0];
          cnt_q  <= '0;
          active <= 1'b1;
        end
        CYC_NEXT:  cnt_q  <= 2'(cnt_q + 2'd1);
        CYC_DESEL: active <= 1'b0;
        default: ;
      endcase
    end
  end

  // R6
  adv_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_NEXT) |=> (cnt_q == 2'($past(cnt_q) + 2'd1)));

  // R6
  hold_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_SAME || cyc == CYC_NONE) |=>
      ($stable(cnt_q) && $stable(hi_q) && $stable(base_q)));

  // R4
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_START) |=>
      (cnt_q == 2'd0 && {hi_q, base_q} == $past(addr_in) && active));

endmodule

// File: rtl/sburst_array.sv
module sburst_array #(
  parameter int DEPTH = 256,
  parameter int NB    = 4,
  parameter int LW    = 9,
  localparam int AW   = $clog2(DEPTH),
  localparam int W    = NB * LW
) (
  input  logic          clk,
  input  logic [NB-1:0] we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LW-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) lane_mem[waddr] <= wdata[g*LW +: LW];
    end

    assign rdata[g*LW +: LW] = lane_mem[raddr];
  end

endmodule

// File: rtl/sburst_ctrl.sv
module sburst_ctrl
  import sburst_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int NB    = 4,
  parameter int LW    = 9,
  localparam int AW   = $clog2(DEPTH),
  localparam int W    = NB * LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          adsp_n,
  input  logic          adsc_n,
  input  logic          adv_n,
  input  logic          interleave,
  input  logic          gw_n,
  input  logic          bw_n,
  input  logic [NB-1:0] be_n,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  din,
  input  logic          oe_n,
  output logic [W-1:0]  dout,
  output logic          dout_en
);

  cyc_e          cyc;
  logic [NB-1:0] wmask;
  logic          active;
  logic [AW-1:0] cur_addr;
  logic [AW-1:0] rd_addr_q;
  logic          rd_q;
  logic [W-1:0]  rdata;
  logic          access;
  logic [NB-1:0] arr_we;

  sburst_decode #(.NB(NB)) u_dec (
    .sleep(sleep), .active(active), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bw_n(bw_n),
    .be_n(be_n), .cyc(cyc), .wmask(wmask)
  );

  sburst_addr_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .cyc(cyc), .interleave(interleave),
    .addr_in(addr), .cur_addr(cur_addr), .active(active)
  );

  assign access = (cyc == CYC_START) || (cyc == CYC_NEXT) || (cyc == CYC_SAME);
  assign arr_we = access ? wmask : '0;

  sburst_array #(.DEPTH(DEPTH), .NB(NB), .LW(LW)) u_arr (
    .clk(clk), .we(arr_we), .waddr(cur_addr), .wdata(din),
    .raddr(rd_addr_q), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_q      <= access && (wmask == '0);
      rd_addr_q <= cur_addr;
    end
  end

  // flow-through: array output straight to pins, gated asynchronously
  assign dout_en = rd_q & ~oe_n & ~sleep;
  assign dout    = dout_en ? rdata : '0;

  // R3
  adsp_read_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !adsp_n && !ce1_n) |-> (arr_we == '0));

  // R9
  no_drive_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    (arr_we != '0) |=> !dout_en);

  // R2
  desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !adsc_n && ce1_n) |=> (!dout_en && !active));

  // R11
  sleep_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (arr_we == '0 && !dout_en));

endmodule

// File: tb/sburst_ctrl_test.sv
module sburst_ctrl_test;

  localparam int DEPTH = 256;
  localparam int NB    = 4;
  localparam int LW    = 9;
  localparam int AW    = 8;
  localparam int W     = 36;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep = 1'b0;
  logic ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic interleave = 1'b0;
  logic gw_n = 1'b1, bw_n = 1'b1;
  logic [NB-1:0] be_n = '1;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  din = '0;
  logic oe_n = 1'b0;
  logic [W-1:0] dout;
  logic dout_en;

  int tests = 0;
  int fails = 0;
  logic [W-1:0] model [DEPTH];

  always #4 clk = ~clk;

  sburst_ctrl #(.DEPTH(DEPTH), .NB(NB), .LW(LW)) uut (
    .clk(clk), .rst(rst), .sleep(sleep), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .interleave(interleave),
    .gw_n(gw_n), .bw_n(bw_n), .be_n(be_n), .addr(addr), .din(din),
    .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [W-1:0] pat(input logic [7:0] a);
    return {4'hA, a, ~a, a ^ 8'h5C, a + 8'd17};
  endfunction

  function automatic logic [7:0] baddr(input logic [7:0] start, input int k,
                                       input logic il);
    logic [1:0] lo;
    lo = il ? (start[1:0] ^ 2'(k)) : 2'(start[1:0] + 2'(k));
    return {start[7:2], lo};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    gw_n = 1'b1; bw_n = 1'b1; be_n = '1; addr = '0; din = '0;
  endtask

  task automatic chk(input string req, input logic exp_en, input logic [W-1:0] exp_d);
    tests++;
    if (dout_en !== exp_en || (exp_en && dout !== exp_d)) begin
      fails++;
      $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
               req, dout_en, dout, exp_en, exp_d);
    end
  endtask

  task automatic c_read(input logic [7:0] a);
    idle_inputs(); adsc_n = 1'b0; addr = a; step(); idle_inputs();
  endtask

  task automatic c_gwrite(input logic [7:0] a, input logic [W-1:0] d);
    idle_inputs(); adsc_n = 1'b0; gw_n = 1'b0; addr = a; din = d; step();
    model[a] = d; idle_inputs();
  endtask

  task automatic cont(input logic adv);
    idle_inputs(); adv_n = adv; step(); idle_inputs();
  endtask

  task automatic t_reset();
    chk("R1 reset output", 1'b0, '0);
    cont(1'b0);
    chk("R1 no burst after reset", 1'b0, '0);
  endtask

  task automatic t_fill();
    for (int a = 0; a < DEPTH; a++) begin
      c_gwrite(8'(a), pat(8'(a)));
      if (a < 3) chk("R9 write not driven", 1'b0, '0);
    end
    c_read(8'h0C);
    chk("R4 R8 controller read", 1'b1, model[8'h0C]);
  endtask

  task automatic t_adsp();
    idle_inputs(); adsp_n = 1'b0; gw_n = 1'b0; addr = 8'h05; din = '0; step();
    idle_inputs();
    chk("R3 processor strobe reads", 1'b1, model[8'h05]);
    c_read(8'h05);
    chk("R3 write inputs ignored", 1'b1, model[8'h05]);
  endtask

  task automatic t_bytes();
    logic [W-1:0] d;
    d = 36'h9_8765_4321;
    idle_inputs(); adsc_n = 1'b0; bw_n = 1'b0; be_n = 4'b1010; addr = 8'h06; din = d;
    step(); idle_inputs();
    chk("R9 byte write undriven", 1'b0, '0);
    model[8'h06][8:0]   = d[8:0];
    model[8'h06][26:18] = d[26:18];
    c_read(8'h06);
    chk("R5 lanes 0 and 2 written", 1'b1, model[8'h06]);
    idle_inputs(); adsc_n = 1'b0; bw_n = 1'b0; be_n = 4'b1111; addr = 8'h06; din = '0;
    step(); idle_inputs();
    chk("R5 no lane enabled is read", 1'b1, model[8'h06]);
    idle_inputs(); adsc_n = 1'b0; gw_n = 1'b0; bw_n = 1'b0; be_n = 4'b1111;
    addr = 8'h07; din = 36'h1_2345_6789; step(); idle_inputs();
    model[8'h07] = 36'h1_2345_6789;
    c_read(8'h07);
    chk("R5 global write all lanes", 1'b1, model[8'h07]);
  endtask

  task automatic t_linear();
    c_read(8'h22);
    chk("R7 linear start", 1'b1, model[8'h22]);
    for (int k = 1; k <= 4; k++) begin
      cont(1'b0);
      chk("R7 R6 linear step", 1'b1, model[baddr(8'h22, k, 1'b0)]);
    end
  endtask

  task automatic t_interleave();
    interleave = 1'b1;
    c_read(8'h31);
    chk("R7 interleave start", 1'b1, model[8'h31]);
    for (int k = 1; k <= 3; k++) begin
      cont(1'b0);
      chk("R7 interleave step", 1'b1, model[baddr(8'h31, k, 1'b1)]);
    end
    interleave = 1'b0;
  endtask

  task automatic t_suspend();
    c_read(8'h70);
    cont(1'b1);
    chk("R6 suspend holds", 1'b1, model[8'h70]);
    cont(1'b0);
    chk("R6 advance after suspend", 1'b1, model[8'h71]);
  endtask

  task automatic t_burst_write();
    c_gwrite(8'h41, 36'h0_0000_1111);
    for (int k = 1; k <= 3; k++) begin
      idle_inputs(); adv_n = 1'b0; gw_n = 1'b0; din = 36'(k * 36'h1_0101); step();
      model[baddr(8'h41, k, 1'b0)] = 36'(k * 36'h1_0101);
      chk("R6 continue write undriven", 1'b0, '0);
    end
    idle_inputs(); adv_n = 1'b1; gw_n = 1'b0; din = 36'h7_7777_7777; step();
    model[8'h40] = 36'h7_7777_7777;
    idle_inputs();
    c_read(8'h41);
    chk("R6 burst write readback", 1'b1, model[8'h41]);
    for (int k = 1; k <= 3; k++) begin
      cont(1'b0);
      chk("R6 burst write readback", 1'b1, model[baddr(8'h41, k, 1'b0)]);
    end
  endtask

  task automatic t_deselect();
    c_read(8'h10);
    idle_inputs(); adsc_n = 1'b0; ce1_n = 1'b1; gw_n = 1'b0; addr = 8'h03;
    din = 36'hF_FFFF_FFFF; step(); idle_inputs();
    chk("R2 deselect by ce1_n", 1'b0, '0);
    cont(1'b0);
    chk("R2 stays idle after deselect", 1'b0, '0);
    c_read(8'h03);
    chk("R2 deselect wrote nothing", 1'b1, model[8'h03]);
    idle_inputs(); adsp_n = 1'b0; ce2 = 1'b0; addr = 8'h04; step(); idle_inputs();
    chk("R2 disabled strobe deselects", 1'b0, '0);
    c_read(8'h50);
    idle_inputs(); adsp_n = 1'b0; ce1_n = 1'b1; adv_n = 1'b0; addr = 8'h90; step();
    idle_inputs();
    chk("R3 blocked processor strobe", 1'b1, model[8'h51]);
  endtask

  task automatic t_e23();
    c_read(8'h60);
    idle_inputs(); adv_n = 1'b0; ce2 = 1'b0; ce3_n = 1'b1; step(); idle_inputs();
    chk("R12 enables ignored mid burst", 1'b1, model[8'h61]);
  endtask

  task automatic t_oe();
    oe_n = 1'b1;
    c_read(8'h80);
    chk("R10 oe high blocks", 1'b0, '0);
    oe_n = 1'b0; #1;
    chk("R10 async enable", 1'b1, model[8'h80]);
    oe_n = 1'b1; #1;
    chk("R10 async disable", 1'b0, '0);
    cont(1'b0);
    oe_n = 1'b0;
    cont(1'b0);
    chk("R10 dummy read advanced", 1'b1, model[8'h82]);
    idle_inputs(); adv_n = 1'b0; gw_n = 1'b0; din = 36'h5_A5A5_A5A5; step();
    model[8'h83] = 36'h5_A5A5_A5A5; idle_inputs();
    chk("R9 write with oe low undriven", 1'b0, '0);
    c_read(8'h83);
    chk("R9 read to write without deselect", 1'b1, model[8'h83]);
  endtask

  task automatic t_sleep();
    c_read(8'h90);
    sleep = 1'b1;
    cont(1'b0);
    chk("R11 sleep undriven", 1'b0, '0);
    idle_inputs(); adsc_n = 1'b0; gw_n = 1'b0; addr = 8'h91; din = '0; step();
    idle_inputs();
    chk("R11 sleep undriven on write", 1'b0, '0);
    sleep = 1'b0;
    cont(1'b0);
    chk("R11 resume position and no write", 1'b1, model[8'h91]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    rst = 1'b1;
    step();
    rst = 1'b0;
    t_reset();
    t_fill();
    t_adsp();
    t_bytes();
    t_linear();
    t_interleave();
    t_suspend();
    t_burst_write();
    t_deselect();
    t_e23();
    t_oe();
    t_sleep();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule